// File: doc/BRIEF.md
# Program Counter and Call Sequencer

This block produces the program-memory fetch address for a small 4-bit controller. A 12-bit program counter advances once for each instruction boundary, which is marked by the `step` strobe. At each boundary the block picks the next address. The candidates are the next sequential address, a jump target, a general call target, one of sixteen short-call slots, a long-call target confined to the lower half of memory, a return address taken from a 13-entry hardware stack, or one of six fixed interrupt vectors. Each call and each accepted interrupt pushes the address of the following instruction.

The instruction decoder drives the control strobes and operand fields. The interrupt sources drive the request lines. Interrupt acceptance is gated by a global enable held inside the block. Software raises the enable with `int_en_set`, and the block lowers it when it takes an interrupt. Stack overflow and stack underflow are reported as sticky flags that are cleared only by reset.

The sequencer is a three-state machine:
- ST_BOOT is the single cycle after reset release. The PC is held at 000h in this state.
- ST_RUN is normal execution.
- ST_VECTOR is a one-cycle entry bubble that follows an accepted interrupt.

Its transitions are BOOT→RUN (always), RUN→VECTOR (interrupt taken), RUN→RUN (any other cycle) and VECTOR→RUN (always).

Top module: `pcseq_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `pc` is 000h and `int_en`, `stk_ovf` and `stk_unf` are 0. A `step` during that first cycle (ST_BOOT) has no effect.
- R2: In ST_RUN, a `step` with no control strobe and no interrupt taken sets `pc` to pc+1 modulo 4096, so FFFh wraps to 000h. Without `step`, `pc` holds.
- R3: `op_jump` loads `pc` with the 12-bit `tgt` and does not touch the stack.
- R4: `op_call` pushes pc+1 and loads `pc` with `tgt`.
- R5: `op_scall` pushes pc+1 and loads `pc` with 00Eh + 8×`slot`, where `slot` is the 4-bit index. Index 3 gives 026h and index 15 gives 086h.
- R6: `op_lcall` pushes pc+1 and loads `pc` with `tgt[10:0]` zero-extended, so the target is always below 800h.
- R7: `op_ret` pops the most recent pushed address into `pc`, in last-in first-out order.
- R8: An accepted interrupt pushes pc+1 and loads the vector 002h + 2×i, where i is the lowest set bit of `irq_req` (bit 0→002h, bit 1→004h, bit 2→006h, bit 3→008h, bit 4→00Ah, bit 5→00Ch).
- R9: An interrupt is taken only on a `step` in ST_RUN with `int_en` = 1 and no control strobe active. Taking it clears `int_en` and enters ST_VECTOR, where `step` is ignored.
- R10: The stack holds 13 return addresses. A push onto a full stack sets `stk_ovf` permanently and leaves all 13 entries intact, while control still transfers to the target.
- R11: `op_ret` on an empty stack sets `stk_unf` permanently and advances `pc` to pc+1.
- R12: `int_en_set` sets `int_en` from the next cycle. If it coincides with interrupt acceptance, the clear wins.
- R13: When several strobes are active together, the priority is `op_ret` > `op_call` > `op_scall` > `op_lcall` > `op_jump`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Instruction boundary strobe |
| op_jump | input | 1 | Jump strobe |
| op_call | input | 1 | General call strobe |
| op_scall | input | 1 | Short-call strobe |
| op_lcall | input | 1 | Long-call strobe |
| op_ret | input | 1 | Return strobe |
| tgt | input | 12 | Jump/call target operand |
| slot | input | 4 | Short-call slot index |
| irq_req | input | 6 | Interrupt requests, bit 0 highest priority |
| int_en_set | input | 1 | Sets the global interrupt enable |
| pc | output | 12 | Current program counter |
| int_en | output | 1 | Global interrupt enable |
| stk_ovf | output | 1 | Sticky stack overflow flag |
| stk_unf | output | 1 | Sticky stack underflow flag |

## Verification
The hardest situation to reach from the ports is a push onto a completely full stack. Verifying it requires showing that none of the 13 stored addresses was disturbed. The stimulus chains thirteen calls from distinct locations and issues a fourteenth. It then unwinds with thirteen returns, comparing each popped address against the call site the bench recorded, and ends with one extra return to reach underflow. Interrupt gating is reached by holding a request while a control strobe is active, then dropping the strobe so the request is accepted. A step issued in the entry bubble confirms it is ignored.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_VECTOR = 2'd2
    } seq_state_e;

    typedef enum logic [3:0] {
        SRC_HOLD  = 4'd0,
        SRC_INC   = 4'd1,
        SRC_JUMP  = 4'd2,
        SRC_CALL  = 4'd3,
        SRC_SCALL = 4'd4,
        SRC_LCALL = 4'd5,
        SRC_RET   = 4'd6,
        SRC_IRQ   = 4'd7
    } next_src_e;

endpackage

// File: rtl/pcseq_irq_pick.sv
module pcseq_irq_pick #(
    parameter int N_IRQ    = 6,
    parameter int PC_W     = 12,
    parameter int VEC_BASE = 2,
    parameter int VEC_STEP = 2
) (
    input  logic [N_IRQ-1:0] req,
    output logic             any,
    output logic [N_IRQ-1:0] grant,
    output logic [PC_W-1:0]  vector
);

    assign any = |req;

    // scan from the top so the lowest requesting index is the one kept
    always_comb begin
        grant  = '0;
        vector = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vector   = PC_W'(VEC_BASE + VEC_STEP * i);
            end
        end
    end

    // R8
    always_comb begin
        r8_grant_onehot_chk: assert ($onehot0(grant));
    end

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target #(
    parameter int PC_W      = 12,
    parameter int SLOT_W    = 4,
    parameter int LCALL_W   = 11,
    parameter int SLOT_BASE = 14,
    parameter int SLOT_STEP = 8
) (
    input  logic [PC_W-1:0]   pc_q,
    input  logic [PC_W-1:0]   tgt,
    input  logic [SLOT_W-1:0] slot,
    output logic [PC_W-1:0]   pc_inc,
    output logic [PC_W-1:0]   scall_addr,
    output logic [PC_W-1:0]   lcall_addr
);

    localparam int LOG_STEP = $clog2(SLOT_STEP);

    assign pc_inc     = pc_q + PC_W'(1);
    assign scall_addr = PC_W'(SLOT_BASE) + (PC_W'(slot) << LOG_STEP);
    assign lcall_addr = {{(PC_W - LCALL_W){1'b0}}, tgt[LCALL_W-1:0]};

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int DEPTH = 13,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign top   = empty ? '0 : mem[cnt - CNT_W'(1)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push && !full) begin
            cnt <= cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[cnt] <= din;
        end
    end

    // R10
    r10_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R10
    r10_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R7
    r7_pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && full) |=> !full);

endmodule

// File: rtl/pcseq_core.sv
module pcseq_core #(
    parameter int PC_W      = 12,
    parameter int DEPTH     = 13,
    parameter int N_IRQ     = 6,
    parameter int SLOT_W    = 4,
    parameter int LCALL_W   = 11,
    parameter int SLOT_BASE = 14,
    parameter int SLOT_STEP = 8,
    parameter int VEC_BASE  = 2,
    parameter int VEC_STEP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              op_jump,
    input  logic              op_call,
    input  logic              op_scall,
    input  logic              op_lcall,
    input  logic              op_ret,
    input  logic [PC_W-1:0]   tgt,
    input  logic [SLOT_W-1:0] slot,
    input  logic [N_IRQ-1:0]  irq_req,
    input  logic              int_en_set,
    output logic [PC_W-1:0]   pc,
    output logic              int_en,
    output logic              stk_ovf,
    output logic              stk_unf
);

    import pcseq_pkg::*;

    seq_state_e state_q, state_d;
    next_src_e  src;

    logic [PC_W-1:0]  pc_inc, scall_addr, lcall_addr, vec_addr, stk_top;
    logic [PC_W-1:0]  pc_d;
    logic [N_IRQ-1:0] irq_grant;
    logic             irq_any, active, any_op, take_irq;
    logic             push, pop, stk_empty, stk_full;

    pcseq_target #(
        .PC_W(PC_W), .SLOT_W(SLOT_W), .LCALL_W(LCALL_W),
        .SLOT_BASE(SLOT_BASE), .SLOT_STEP(SLOT_STEP)
    ) i_target (
        .pc_q(pc), .tgt(tgt), .slot(slot),
        .pc_inc(pc_inc), .scall_addr(scall_addr), .lcall_addr(lcall_addr)
    );

    pcseq_irq_pick #(
        .N_IRQ(N_IRQ), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) i_irq_pick (
        .req(irq_req), .any(irq_any), .grant(irq_grant), .vector(vec_addr)
    );

    pcseq_stack #(.DEPTH(DEPTH), .W(PC_W)) i_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(pc_inc),
        .top(stk_top), .empty(stk_empty), .full(stk_full)
    );

    assign active   = (state_q == ST_RUN) && step;
    assign any_op   = op_ret | op_call | op_scall | op_lcall | op_jump;
    assign take_irq = active && !any_op && int_en && irq_any;

    // source selection; order encodes the strobe priority
    always_comb begin
        src = SRC_HOLD;
        if (active) begin
            if (take_irq)      src = SRC_IRQ;
            else if (op_ret)   src = stk_empty ? SRC_INC : SRC_RET;
            else if (op_call)  src = SRC_CALL;
            else if (op_scall) src = SRC_SCALL;
            else if (op_lcall) src = SRC_LCALL;
            else if (op_jump)  src = SRC_JUMP;
            else               src = SRC_INC;
        end
    end

    assign push = (src == SRC_IRQ) || (src == SRC_CALL) ||
                  (src == SRC_SCALL) || (src == SRC_LCALL);
    assign pop  = active && !take_irq && op_ret;

    always_comb begin
        unique case (src)
            SRC_HOLD:  pc_d = pc;
            SRC_INC:   pc_d = pc_inc;
            SRC_JUMP:  pc_d = tgt;
            SRC_CALL:  pc_d = tgt;
            SRC_SCALL: pc_d = scall_addr;
            SRC_LCALL: pc_d = lcall_addr;
            SRC_RET:   pc_d = stk_top;
            SRC_IRQ:   pc_d = vec_addr;
            default:   pc_d = pc;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_RUN;
            ST_RUN:    state_d = take_irq ? ST_VECTOR : ST_RUN;
            ST_VECTOR: state_d = ST_RUN;
            default:   state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc      <= '0;
            int_en  <= 1'b0;
            stk_ovf <= 1'b0;
            stk_unf <= 1'b0;
        end else begin
            pc <= pc_d;
            if (take_irq)        int_en <= 1'b0;
            else if (int_en_set) int_en <= 1'b1;
            if (push && stk_full)  stk_ovf <= 1'b1;
            if (pop && stk_empty)  stk_unf <= 1'b1;
        end
    end

    // R1
    r1_boot_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |-> (pc == '0));

    // R2
    r2_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && step && !any_op && !(int_en && irq_any))
        |=> (pc == PC_W'($past(pc) + 1)));

    // R2
    r2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN || !step) |=> $stable(pc));

    // R9
    r9_vector_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VECTOR) |-> !int_en);

    // R10
    r10_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |=> stk_ovf);

    // R11
    r11_unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_unf |=> stk_unf);

    // R6
    r6_lcall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && op_lcall && !op_ret && !op_call && !op_scall)
        |=> (pc[PC_W-1:LCALL_W] == '0));

endmodule

// File: tb/test_pcseq_core.sv
`timescale 1ns/1ps
module test_pcseq_core;

    logic        clk = 1'b0;
    logic        rst_n, step, op_jump, op_call, op_scall, op_lcall, op_ret;
    logic [11:0] tgt;
    logic [3:0]  slot;
    logic [5:0]  irq_req;
    logic        int_en_set;
    logic [11:0] pc;
    logic        int_en, stk_ovf, stk_unf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pcseq_core i_pcseq_core (
        .clk(clk), .rst_n(rst_n), .step(step), .op_jump(op_jump),
        .op_call(op_call), .op_scall(op_scall), .op_lcall(op_lcall),
        .op_ret(op_ret), .tgt(tgt), .slot(slot), .irq_req(irq_req),
        .int_en_set(int_en_set), .pc(pc), .int_en(int_en),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    // {step, ret,call,scall,lcall,jump, tgt, slot, irq, ies, expected pc}
    localparam logic [40:0] VTBL [20] = '{
        {1'b1, 5'b00000, 12'h000, 4'h0, 6'b000000, 1'b0, 12'h001}, // R2
        {1'b1, 5'b00001, 12'h123, 4'h0, 6'b000000, 1'b0, 12'h123}, // R3
        {1'b1, 5'b01000, 12'h456, 4'h0, 6'b000000, 1'b0, 12'h456}, // R4
        {1'b1, 5'b00100, 12'h000, 4'h3, 6'b000000, 1'b0, 12'h026}, // R5
        {1'b1, 5'b00010, 12'hFAB, 4'h0, 6'b000000, 1'b0, 12'h7AB}, // R6
        {1'b1, 5'b00000, 12'h000, 4'h0, 6'b000000, 1'b0, 12'h7AC}, // R2
        {1'b1, 5'b10000, 12'h000, 4'h0, 6'b000000, 1'b0, 12'h027}, // R7
        {1'b1, 5'b10000, 12'h000, 4'h0, 6'b000000, 1'b0, 12'h457}, // R7
        {1'b0, 5'b00001, 12'h111, 4'h0, 6'b000000, 1'b0, 12'h457}, // R2 hold
        {1'b1, 5'b10000, 12'h000, 4'h0, 6'b000000, 1'b0, 12'h124}, // R7
        {1'b1, 5'b00001, 12'hFFF, 4'h0, 6'b000000, 1'b0, 12'hFFF}, // R3
        {1'b1, 5'b00000, 12'h000, 4'h0, 6'b000000, 1'b0, 12'h000}, // R2 wrap
        {1'b1, 5'b00000, 12'h000, 4'h0, 6'b000000, 1'b1, 12'h001}, // R12
        {1'b1, 5'b00110, 12'h000, 4'hF, 6'b000100, 1'b0, 12'h086}, // R13 R9
        {1'b1, 5'b00000, 12'h000, 4'h0, 6'b010100, 1'b0, 12'h006}, // R8
        {1'b1, 5'b00001, 12'h200, 4'h0, 6'b010100, 1'b0, 12'h006}, // R9 bubble
        {1'b1, 5'b00000, 12'h000, 4'h0, 6'b010100, 1'b0, 12'h007}, // R9 masked
        {1'b1, 5'b11001, 12'h555, 4'h0, 6'b000000, 1'b0, 12'h087}, // R13 ret
        {1'b1, 5'b10000, 12'h000, 4'h0, 6'b000000, 1'b0, 12'h002}, // R7
        {1'b1, 5'b10000, 12'h000, 4'h0, 6'b000000, 1'b0, 12'h003}  // R11
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic [4:0] ops, input logic [11:0] t,
                         input logic [3:0] sl, input logic [5:0] irq, input logic ies);
        step = s;
        {op_ret, op_call, op_scall, op_lcall, op_jump} = ops;
        tgt = t; slot = sl; irq_req = irq; int_en_set = ies;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step = 1'b0; {op_ret, op_call, op_scall, op_lcall, op_jump} = '0;
        tgt = '0; slot = '0; irq_req = '0; int_en_set = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        logic [11:0] exp_pc;
        logic [11:0] site [13];
        do_reset();
        // R1 reset state
        check("R1 pc", pc, 12'h000);
        check("R1 flags", {9'd0, int_en, stk_ovf, stk_unf}, 12'h000);
        // R1 boot cycle ignores step
        drive(1'b1, 5'b00001, 12'h3C3, 4'h0, 6'b0, 1'b0);
        check("R1 boot", pc, 12'h000);

        for (int i = 0; i < 20; i++) begin
            drive(VTBL[i][40], VTBL[i][39:35], VTBL[i][34:23], VTBL[i][22:19],
                  VTBL[i][18:13], VTBL[i][12]);
            check($sformatf("R2-table row %0d", i), pc, VTBL[i][11:0]);
            if (i == 14) check("R9 int_en cleared", {11'd0, int_en}, 12'h000);
        end
        check("R11 unf flag", {11'd0, stk_unf}, 12'h001);
        check("R10 no ovf", {11'd0, stk_ovf}, 12'h000);

        // R10 overflow: 13 calls fill the stack, the 14th overflows
        do_reset();
        drive(1'b0, 5'b0, 12'h0, 4'h0, 6'b0, 1'b0);
        exp_pc = 12'h000;
        for (int k = 0; k < 13; k++) begin
            site[k] = exp_pc + 12'd1;
            exp_pc  = 12'h100 + 12'(k * 16);
            drive(1'b1, 5'b01000, exp_pc, 4'h0, 6'b0, 1'b0);
        end
        check("R10 full no ovf", {11'd0, stk_ovf}, 12'h000);
        drive(1'b1, 5'b01000, 12'hA00, 4'h0, 6'b0, 1'b0);
        check("R10 transfer on full", pc, 12'hA00);
        check("R10 ovf set", {11'd0, stk_ovf}, 12'h001);
        for (int k = 12; k >= 0; k--) begin
            drive(1'b1, 5'b10000, 12'h0, 4'h0, 6'b0, 1'b0);
            check($sformatf("R10 R7 unwind %0d", k), pc, site[k]);
        end
        drive(1'b1, 5'b10000, 12'h0, 4'h0, 6'b0, 1'b0);
        check("R11 pc after empty ret", pc, 12'h002);
        check("R11 unf set", {11'd0, stk_unf}, 12'h001);
        check("R10 ovf sticky", {11'd0, stk_ovf}, 12'h001);

        // R8 every vector, one request at a time
        do_reset();
        drive(1'b0, 5'b0, 12'h0, 4'h0, 6'b0, 1'b0);
        exp_pc = 12'h000;
        for (int v = 0; v < 6; v++) begin
            drive(1'b1, 5'b0, 12'h0, 4'h0, 6'b0, 1'b1);
            exp_pc = exp_pc + 12'd1;
            check("R12 enable", {11'd0, int_en}, 12'h001);
            drive(1'b1, 5'b0, 12'h0, 4'h0, 6'(1 << v), 1'b0);
            check($sformatf("R8 vector %0d", v), pc, 12'(2 + 2 * v));
            drive(1'b1, 5'b0, 12'h0, 4'h0, 6'b0, 1'b0);
            check("R9 bubble", pc, 12'(2 + 2 * v));
            drive(1'b1, 5'b10000, 12'h0, 4'h0, 6'b0, 1'b0);
            exp_pc = exp_pc + 12'd1;
            check("R8 return", pc, exp_pc);
        end

        // R12 clear wins over simultaneous set
        drive(1'b1, 5'b0, 12'h0, 4'h0, 6'b0, 1'b1);
        drive(1'b1, 5'b0, 12'h0, 4'h0, 6'b100000, 1'b1);
        check("R8 vector 5 again", pc, 12'h00C);
        check("R12 clear wins", {11'd0, int_en}, 12'h000);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule